// File: doc/BRIEF.md
# Registered Command/Address Buffer with Delayed Parity Check

This block sits on the command/address path of a registered memory module. On every rising clock edge it captures the address and command bits, the clock-enable and on-die-termination controls, and the chip selects. It then drives the registered values to two output copies, an A side and a B side, so that each side can feed its own group of memory devices.

A static mode pin selects how chip selects are handled. In dual-select mode two select inputs each fan out to one A-side and one B-side output. In quad-select mode four select inputs each drive their own output.

The block also checks even parity over the address and command bits. The parity bit for a cycle's data arrives one clock later than that data. The check runs only for cycles in which the data was addressed to a device, meaning at least one valid chip select was low. A mismatch pulls an active-low error flag low for a fixed number of cycles.

Top module: `cmd_reg_buf`

## Requirements
- R1: `cmd_a_o` equals the `cmd_i` value captured at the most recent rising edge of `clk_i`, one cycle of latency.
- R2: `cmd_b_o` carries the same registered value as `cmd_a_o` on every cycle.
- R3: `cke_a_o`/`cke_b_o` and `odt_a_o`/`odt_b_o` are both the registered `cke_i` and `odt_i`.
- R4: With `quad_cs_ni` = 1 (dual-select mode), `cs_no[0]` and `cs_no[2]` are the registered `cs_ni[0]`, and `cs_no[1]` and `cs_no[3]` are the registered `cs_ni[1]`.
- R5: With `quad_cs_ni` = 0 (quad-select mode), each `cs_no[k]` is the registered `cs_ni[k]`, k = 0..3.
- R6: In dual-select mode `cs_ni[3:2]` has no effect on `cs_no` and does not qualify a parity check.
- R7: A parity mismatch pulls `err_no` low. A mismatch means the XOR of all `cmd_i` bits of a qualified cycle differs from `par_i`, so the parity is even over data plus parity bit.
- R8: The parity bit compared against a cycle's `cmd_i` is the `par_i` sampled at the next rising edge. `err_no` falls right after that edge.
- R9: A cycle is qualified only if at least one chip select valid in the current mode is low. Unqualified cycles never cause an error.
- R10: `cke_i`, `odt_i` and `cs_ni` do not enter the parity sum.
- R11: After a mismatch `err_no` stays low for exactly 2 cycles (`ERR_HOLD`) and then returns high. A further mismatch restarts the hold.
- R12: While `rst_ni` is low, all chip-select outputs are high, `err_no` is high, and the command and control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| quad_cs_ni | input | 1 | Static mode pin: 1 = dual-select, 0 = quad-select |
| cmd_i | input | CMD_W | Address and command bits |
| cke_i | input | CKE_W | Clock-enable controls |
| odt_i | input | ODT_W | On-die-termination controls |
| cs_ni | input | 4 | Chip selects, active low |
| par_i | input | 1 | Parity bit for the previous cycle's `cmd_i` |
| cmd_a_o | output | CMD_W | Registered command, A side |
| cmd_b_o | output | CMD_W | Registered command, B side |
| cke_a_o | output | CKE_W | Registered clock enables, A side |
| cke_b_o | output | CKE_W | Registered clock enables, B side |
| odt_a_o | output | ODT_W | Registered termination controls, A side |
| odt_b_o | output | ODT_W | Registered termination controls, B side |
| cs_no | output | 4 | Registered chip selects, active low |
| err_no | output | 1 | Parity error flag, active low |

## Verification
The bench runs four parity scenarios:
- Correct parity presented one cycle late. A design that compared against the same-cycle bit would flag an error here.
- Wrong parity on unselected cycles, and with only the unused upper selects low in dual-select mode. A design that skipped the qualification, or decoded all four selects in dual-select mode, would pull the flag low.
- Toggling the control inputs while the parity is kept correct for the command bits alone. A design that folded the controls into the sum would report false errors.
- Back-to-back mismatches. The flag must stay low through the restarted hold window and rise exactly two cycles after the last one; an off-by-one counter shows up as a one-cycle shift.

// File: rtl/cmd_buf_pkg.sv
package cmd_buf_pkg;
  localparam logic MODE_QUAD = 1'b0;
  localparam logic MODE_DUAL = 1'b1;
  localparam int unsigned CS_W = 4;
  localparam int unsigned CS_DUAL_W = CS_W / 2;

  function automatic logic even_par(input logic [63:0] bits, input int unsigned w);
    logic p;
    p = 1'b0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < w) p ^= bits[i];
    end
    return p;
  endfunction
endpackage

// File: rtl/dup_reg.sv
module dup_reg #(
  parameter int unsigned W = 8,
  parameter int unsigned COPIES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [W-1:0]              d_i,
  output logic [COPIES-1:0][W-1:0]  q_o
);
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic [W-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= RST_VAL;
      else         q_q <= d_i;
    end
    assign q_o[c] = q_q;

    // R1 R2 R3: every copy holds the value captured one edge earlier
    assert_copy_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> q_o[c] == $past(d_i));
  end
endmodule

// File: rtl/cs_router.sv
module cs_router
  import cmd_buf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            quad_cs_ni,
  input  logic [CS_W-1:0] cs_ni,
  output logic [CS_W-1:0] cs_no,
  output logic            qual_o
);
  logic [CS_W-1:0] cs_d, cs_q;

  // dual mode: output k mirrors input k mod 2 (A side low half, B side high half)
  for (genvar k = 0; k < CS_W; k++) begin : g_map
    assign cs_d[k] = (quad_cs_ni == MODE_QUAD) ? cs_ni[k] : cs_ni[k % CS_DUAL_W];
  end

  assign qual_o = (quad_cs_ni == MODE_QUAD) ? ~&cs_ni : ~&cs_ni[CS_DUAL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= '1;
    else         cs_q <= cs_d;
  end
  assign cs_no = cs_q;

  assert_dual_mirror_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_cs_ni == MODE_DUAL) |=> cs_no == {2{$past(cs_ni[CS_DUAL_W-1:0])}});

  assert_quad_direct_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_cs_ni == MODE_QUAD) |=> cs_no == $past(cs_ni));
endmodule

// File: rtl/par_check.sv
module par_check
  import cmd_buf_pkg::*;
#(
  parameter int unsigned CMD_W = 22,
  parameter int unsigned ERR_HOLD = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             qual_i,
  input  logic             par_i,
  output logic             err_no
);
  localparam int unsigned CNT_W = $clog2(ERR_HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_VAL = CNT_W'(ERR_HOLD);

  logic             pend_q, calc_q, mismatch;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      calc_q <= 1'b0;
    end else begin
      pend_q <= qual_i;
      calc_q <= even_par(64'(cmd_i), CMD_W);
    end
  end

  // late parity bit checked against the data captured one edge before
  assign mismatch = pend_q & (calc_q ^ par_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (mismatch)     cnt_q <= HOLD_VAL;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign err_no = (cnt_q == '0);

  assert_unqualified_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_no && !pend_q) |=> err_no);

  if (ERR_HOLD >= 2) begin : g_hold_chk
    assert_err_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(err_no) |=> !err_no);
  end
endmodule

// File: rtl/cmd_reg_buf.sv
module cmd_reg_buf
  import cmd_buf_pkg::*;
#(
  parameter int unsigned CMD_W = 22,
  parameter int unsigned CKE_W = 2,
  parameter int unsigned ODT_W = 2,
  parameter int unsigned ERR_HOLD = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             quad_cs_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [CKE_W-1:0] cke_i,
  input  logic [ODT_W-1:0] odt_i,
  input  logic [3:0]       cs_ni,
  input  logic             par_i,
  output logic [CMD_W-1:0] cmd_a_o,
  output logic [CMD_W-1:0] cmd_b_o,
  output logic [CKE_W-1:0] cke_a_o,
  output logic [CKE_W-1:0] cke_b_o,
  output logic [ODT_W-1:0] odt_a_o,
  output logic [ODT_W-1:0] odt_b_o,
  output logic [3:0]       cs_no,
  output logic             err_no
);
  localparam int unsigned CTL_W = CKE_W + ODT_W;

  logic [1:0][CMD_W-1:0] cmd_q;
  logic [1:0][CTL_W-1:0] ctl_q;
  logic                  qual;

  dup_reg #(.W(CMD_W), .COPIES(2)) i_cmd_reg (
    .clk_i, .rst_ni, .d_i(cmd_i), .q_o(cmd_q)
  );

  dup_reg #(.W(CTL_W), .COPIES(2)) i_ctl_reg (
    .clk_i, .rst_ni, .d_i({odt_i, cke_i}), .q_o(ctl_q)
  );

  cs_router i_cs_router (
    .clk_i, .rst_ni, .quad_cs_ni, .cs_ni, .cs_no, .qual_o(qual)
  );

  par_check #(.CMD_W(CMD_W), .ERR_HOLD(ERR_HOLD)) i_par_check (
    .clk_i, .rst_ni, .cmd_i, .qual_i(qual), .par_i, .err_no
  );

  assign cmd_a_o = cmd_q[0];
  assign cmd_b_o = cmd_q[1];
  assign cke_a_o = ctl_q[0][CKE_W-1:0];
  assign cke_b_o = ctl_q[1][CKE_W-1:0];
  assign odt_a_o = ctl_q[0][CTL_W-1:CKE_W];
  assign odt_b_o = ctl_q[1][CTL_W-1:CKE_W];

  assert_sides_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cmd_a_o == cmd_b_o) && (cke_a_o == cke_b_o) && (odt_a_o == odt_b_o));
endmodule

// File: tb/test_cmd_reg_buf.sv
`timescale 1ns/1ps
module test_cmd_reg_buf;
  localparam int CMD_W = 22;
  localparam real HALF = 4.0;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             quad_cs_ni = 1'b1;
  logic [CMD_W-1:0] cmd_i = '0;
  logic [1:0]       cke_i = '0, odt_i = '0;
  logic [3:0]       cs_ni = '1;
  logic             par_i = 1'b0;
  logic [CMD_W-1:0] cmd_a_o, cmd_b_o;
  logic [1:0]       cke_a_o, cke_b_o, odt_a_o, odt_b_o;
  logic [3:0]       cs_no;
  logic             err_no;

  cmd_reg_buf #(.CMD_W(CMD_W)) i_cmd_reg_buf (.*);

  always #(HALF) clk_i = ~clk_i;

  typedef struct {
    logic [CMD_W-1:0] cmd;
    logic [1:0]       cke, odt;
    logic [3:0]       cs;
    logic             err;
    string            cs_tag;
    string            err_tag;
  } exp_t;

  exp_t sb_q[$];
  int total = 0, bad = 0;

  // reference state built from the requirements
  logic             m_pend = 0, m_calc = 0;
  int               m_cnt = 0;
  logic [CMD_W-1:0] prev_cmd = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    #1;
    if (rst_ni && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk("R1 cmd_a", 32'(cmd_a_o), 32'(e.cmd));
      chk("R2 cmd_b", 32'(cmd_b_o), 32'(e.cmd));
      chk("R3 cke/odt", {24'd0, cke_a_o, cke_b_o, odt_a_o, odt_b_o},
          {24'd0, e.cke, e.cke, e.odt, e.odt});
      chk(e.cs_tag, 32'(cs_no), 32'(e.cs));
      chk(e.err_tag, 32'(err_no), 32'(e.err));
    end
  end

  // one cycle of stimulus; bad_par flips the late parity bit for the previous cycle
  task automatic step(logic [CMD_W-1:0] cmd, logic [1:0] cke, logic [1:0] odt,
                      logic [3:0] cs, logic bad_par, string err_tag);
    exp_t e;
    logic par, mism;
    @(negedge clk_i);
    par = (^prev_cmd) ^ bad_par;
    cmd_i = cmd; cke_i = cke; odt_i = odt; cs_ni = cs; par_i = par;
    mism = m_pend && (m_calc ^ par);
    if (mism) m_cnt = 2;
    else if (m_cnt > 0) m_cnt--;
    m_pend = quad_cs_ni ? ~&cs[1:0] : ~&cs;
    m_calc = ^cmd;
    prev_cmd = cmd;
    e.cmd = cmd; e.cke = cke; e.odt = odt;
    e.cs = quad_cs_ni ? {cs[1:0], cs[1:0]} : cs;
    e.cs_tag = quad_cs_ni ? "R4/R6 dual cs" : "R5 quad cs";
    e.err = (m_cnt == 0);
    e.err_tag = err_tag;
    sb_q.push_back(e);
  endtask

  task automatic do_reset(logic mode);
    wait (sb_q.size() == 0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    quad_cs_ni = mode;
    cmd_i = '1; cke_i = '1; odt_i = '1; cs_ni = '0; par_i = 1'b1;
    @(negedge clk_i);
    // R12: reset levels
    chk("R12 cs", 32'(cs_no), 32'hF);
    chk("R12 err", 32'(err_no), 32'h1);
    chk("R12 cmd", 32'(cmd_a_o | cmd_b_o), 32'h0);
    chk("R12 ctl", {28'd0, cke_a_o | cke_b_o, odt_a_o | odt_b_o}, 32'h0);
    m_pend = 0; m_calc = 0; m_cnt = 0; prev_cmd = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  function automatic logic [CMD_W-1:0] pat(int i);
    return CMD_W'(32'h9E37_79B1 * (i + 3) ^ (i << 7));
  endfunction

  initial begin
    #(200000 * 2 * HALF);
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // ---- dual-select mode ----
    do_reset(1'b1);
    for (int i = 0; i < 6; i++)
      step(pat(i), 2'(i), 2'(i + 1), 4'b1111, 1'b0, "R7 good parity");
    // R9: wrong parity for unselected cycles
    for (int i = 0; i < 4; i++)
      step(pat(i + 10), 2'b01, 2'b10, 4'b1111, 1'b1, "R9 unqualified");
    // R6: only upper selects low in dual mode, with wrong parity following
    step(pat(20), 2'b00, 2'b00, 4'b0011, 1'b0, "R6 upper cs");
    step(pat(21), 2'b00, 2'b00, 4'b0111, 1'b1, "R6 upper cs ignored");
    step(pat(22), 2'b00, 2'b00, 4'b1011, 1'b1, "R6 upper cs ignored");
    step(pat(23), 2'b00, 2'b00, 4'b1111, 1'b1, "R6 upper cs ignored");
    // R8: selected cycle with parity correct one cycle late
    step(pat(30), 2'b11, 2'b01, 4'b1110, 1'b0, "R8 late good");
    step(pat(31), 2'b00, 2'b11, 4'b1101, 1'b0, "R8 late good");
    step(pat(32), 2'b10, 2'b00, 4'b1111, 1'b0, "R8 late good");
    // R10: controls toggle, parity over cmd only stays clean
    for (int i = 0; i < 6; i++)
      step(pat(40 + i), 2'(i * 3), 2'(i ^ 3), {2'(i), 2'b10}, 1'b0, "R10 ctl excluded");
    // R7/R11: single mismatch, low for two cycles
    step(pat(50), 2'b01, 2'b01, 4'b1101, 1'b0, "R7 setup");
    step(pat(51), 2'b01, 2'b01, 4'b1111, 1'b1, "R7 mismatch low");
    step(pat(52), 2'b01, 2'b01, 4'b1111, 1'b1, "R11 hold cycle 2");
    step(pat(53), 2'b01, 2'b01, 4'b1111, 1'b0, "R11 released");
    step(pat(54), 2'b01, 2'b01, 4'b1111, 1'b0, "R11 stays high");
    // R11: back-to-back mismatches restart the hold
    step(pat(60), 2'b00, 2'b00, 4'b1110, 1'b0, "R11 setup");
    step(pat(61), 2'b00, 2'b00, 4'b1110, 1'b1, "R11 first");
    step(pat(62), 2'b00, 2'b00, 4'b1111, 1'b1, "R11 second");
    step(pat(63), 2'b00, 2'b00, 4'b1111, 1'b0, "R11 hold");
    step(pat(64), 2'b00, 2'b00, 4'b1111, 1'b0, "R11 hold end");
    step(pat(65), 2'b00, 2'b00, 4'b1111, 1'b0, "R11 back high");

    // ---- quad-select mode ----
    do_reset(1'b0);
    for (int i = 0; i < 4; i++)
      step(pat(70 + i), 2'(i), 2'(~i), 4'(1 << i) ^ 4'hF, 1'b0, "R5 good parity");
    // upper select alone qualifies in quad mode
    step(pat(80), 2'b00, 2'b00, 4'b0111, 1'b0, "R9 quad setup");
    step(pat(81), 2'b00, 2'b00, 4'b1111, 1'b1, "R9 quad qualified");
    step(pat(82), 2'b00, 2'b00, 4'b1111, 1'b1, "R9 quad unqualified");
    step(pat(83), 2'b00, 2'b00, 4'b1111, 1'b0, "R11 quad hold");
    step(pat(84), 2'b00, 2'b00, 4'b1010, 1'b0, "R11 quad release");
    step(pat(85), 2'b11, 2'b11, 4'b0101, 1'b0, "R5 mixed cs");
    step(pat(86), 2'b11, 2'b11, 4'b1111, 1'b0, "R5 idle");

    wait (sb_q.size() == 0);
    @(negedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule